// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block is the clocked read front end of a memory organised in 32-bit words. A host pulses an address-valid strobe together with a word address and an address-space select. After a programmable initial latency, the block returns data from an internal array model. When bursts are enabled it returns one word per clock through a linear burst of 2, 4 or 8 words. The burst wraps inside a group aligned to its own length. It keeps repeating from the start address for as long as the clock runs. A last-beat indicator comes with the final word before each wrap, so the host knows when to strobe the next address.

A 7-bit configuration word selects burst enable, burst length and latency. Reads of the configuration word and of the protection bits are always single reads, even with bursts on. A single read keeps its word valid for as long as output enable stays high. A small secure region of 64 words (256 bytes) is also readable. Any beat that falls outside it returns zero data with an invalid flag.

Top module: `burst_read_seq`

## Requirements
- R1: After reset rdValid, rdLast and rdBad are low and rdData is zero. The configuration resets to bursts off, 4-word length and latency code 0.
- R2: The configuration word is {latency code[6:3], length select[2:1], burst enable[0]}. Length select 00 means 2 words, 01 means 4, and 10 or 11 means 8. The latency is code+2 clocks, and code 15 gives 16. A write takes effect at the cfgWrEn edge. A strobe at that same edge, and any burst already running, keep the values latched when their strobe was sampled.
- R3: The first word of a read appears at the L-th rising edge after the edge that samples addrValid, where L is the latency.
- R4: In burst mode the word addresses follow (base & ~(N-1)) | ((base+i) & (N-1)) for beat i = 0,1,2…, one word per clock. The upper address bits stay fixed.
- R5: rdLast is high only with the beat whose index is N-1 counted from the start address. It is never high in a single read.
- R6: With no new strobe, the beat after the last one returns the start address again, and the sequence repeats without end.
- R7: With bursts disabled, a read returns one word after the latency. It stays valid while outEn is high, and ends at the first later edge where outEn is sampled low.
- R8: Space select 2 reads the configuration word zero-extended, and space 3 reads the protection bits (default 8'h5A) zero-extended. Both are single reads even when bursts are enabled.
- R9: A strobe during the latency or during a burst aborts it. Outputs are invalid from that edge on, and the latency restarts at the new address.
- R10: Space 1 is the secure region. A beat at word address below 64 returns {16'h5EC0, address}. A beat at 64 or above returns zero data with rdBad high.
- R11: While outEn is low, rdValid, rdLast and rdBad are low and rdData is zero. A running burst still advances.
- R12: Space 0 is the main array, and word address a returns {a ^ 16'hC3A5, a}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Address strobe, starts a new read |
| addr | input | ADDR_W | Word start address |
| space | input | 2 | 0 main, 1 secure, 2 configuration, 3 protection |
| outEn | input | 1 | Output enable |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 7 | Configuration value to write |
| rdData | output | 32 | Read word, zero when not valid |
| rdValid | output | 1 | Word on rdData is valid |
| rdLast | output | 1 | Final beat before the burst wraps |
| rdBad | output | 1 | Beat lies outside the secure region |

## Verification
The hardest state to reach is a strobe or configuration write that lands on a particular cycle. Examples are a strobe that arrives while the latency is still counting, one that arrives in the middle of a burst, or a configuration write on the very edge that samples a strobe. The stimulus is aligned to clock edges, so each strobe can be placed at a chosen offset from the previous one. The bench's reference model computes every expected beat from the edge count since the last strobe. A burst with latency 16 and length 8 is run long enough to wrap several times. Output enable is dropped both in the middle of a burst and during a held single read.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int BEAT_W = 3;
  localparam int CFG_W  = 7;
  localparam logic [15:0] MAIN_SALT  = 16'hC3A5;
  localparam logic [15:0] SECURE_TAG = 16'h5EC0;

  typedef enum logic [1:0] {
    SPACE_MAIN   = 2'd0,
    SPACE_SECURE = 2'd1,
    SPACE_CFG    = 2'd2,
    SPACE_PROT   = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;

  // configuration word: latency code, length select, burst enable (MSB first)
  typedef struct packed {
    logic [3:0] latCode;
    logic [1:0] lenSel;
    logic       burstOn;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic              load;
    logic              clear;
    logic              last;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] mask;
  } dp_ctl_t;

  function automatic logic [4:0] latencyOf(cfg_t c);
    return (c.latCode == 4'hF) ? 5'd16 : ({1'b0, c.latCode} + 5'd2);
  endfunction

  function automatic logic [BEAT_W-1:0] maskOf(logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 7'b0000_010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrValid,
  input  logic [1:0]           space,
  input  logic                 outEn,
  input  logic                 cfgWrEn,
  input  logic [CFG_W-1:0]     cfgWrData,
  output cfg_t                 cfgQ,
  output dp_ctl_t              ctl
);

  seq_state_e        stateQ;
  logic [4:0]        waitQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] maskQ;
  logic              burstQ;
  logic              burstSel;
  logic              firstBeat;

  assign burstSel  = cfgQ.burstOn &&
                     ((space_e'(space) == SPACE_MAIN) || (space_e'(space) == SPACE_SECURE));
  assign firstBeat = (stateQ == ST_WAIT) && (waitQ == 5'd0);

  // configuration register; a strobe on the same edge still sees the old value
  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= cfg_t'(CFG_RESET);
    else if (cfgWrEn) cfgQ <= cfg_t'(cfgWrData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      waitQ  <= '0;
      beatQ  <= '0;
      maskQ  <= 3'd1;
      burstQ <= 1'b0;
    end else if (addrValid) begin
      stateQ <= ST_WAIT;
      waitQ  <= latencyOf(cfgQ) - 5'd1;
      beatQ  <= '0;
      maskQ  <= maskOf(cfgQ.lenSel);
      burstQ <= burstSel;
    end else begin
      case (stateQ)
        ST_WAIT: begin
          if (waitQ == 5'd0) begin
            stateQ <= burstQ ? ST_BURST : ST_HOLD;
            beatQ  <= (beatQ + 3'd1) & maskQ;
          end else begin
            waitQ <= waitQ - 5'd1;
          end
        end
        ST_BURST: beatQ  <= (beatQ + 3'd1) & maskQ;
        ST_HOLD:  if (!outEn) stateQ <= ST_IDLE;
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.capture = addrValid;
    ctl.load    = !addrValid && (firstBeat || (stateQ == ST_BURST));
    ctl.clear   = !addrValid && (stateQ == ST_HOLD) && !outEn;
    ctl.last    = burstQ && (beatQ == maskQ);
    ctl.beat    = beatQ;
    ctl.mask    = maskQ;
  end

  // independent latency watch: edges counted since the strobe
  logic [4:0] chkCount;
  logic [4:0] chkLat;
  logic       chkFirst;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkCount <= '0;
      chkLat   <= '0;
      chkFirst <= 1'b0;
    end else if (addrValid) begin
      chkCount <= 5'd1;
      chkLat   <= latencyOf(cfgQ);
      chkFirst <= 1'b1;
    end else if (chkFirst && ctl.load) begin
      chkFirst <= 1'b0;
    end else if (chkFirst && chkCount != 5'd31) begin
      chkCount <= chkCount + 5'd1;
    end
  end

  assert_first_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chkFirst && ctl.load) |-> (chkCount == chkLat));

  assert_hold_while_enabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && outEn && !addrValid) |=> (stateQ == ST_HOLD));

endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               SEC_WORDS = 64,
  parameter int               PROT_W    = 8,
  parameter logic [PROT_W-1:0] PROT_INIT = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        space,
  input  logic              outEn,
  input  dp_ctl_t           ctl,
  input  cfg_t              cfgQ,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              rdLast,
  output logic              rdBad
);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] presQ;
  space_e            spaceQ;
  logic [31:0]       dataQ;
  logic              validQ, lastQ, badQ;

  logic [ADDR_W-1:0] maskExt;
  logic [ADDR_W-1:0] beatAddr;
  logic [15:0]       a16;
  logic [31:0]       nextData;
  logic              nextBad;
  logic [31:0]       protWord;

  assign maskExt  = ADDR_W'(ctl.mask);
  assign beatAddr = (baseQ & ~maskExt) | ((baseQ + ADDR_W'(ctl.beat)) & maskExt);

  always_comb begin
    a16 = '0;
    a16[ADDR_W-1:0] = beatAddr;
    protWord = '0;
    protWord[PROT_W-1:0] = PROT_INIT;
  end

  always_comb begin
    nextBad  = 1'b0;
    nextData = '0;
    case (spaceQ)
      SPACE_MAIN:   nextData = {a16 ^ MAIN_SALT, a16};
      SPACE_SECURE: begin
        if ({16'b0, a16} < 32'(SEC_WORDS)) nextData = {SECURE_TAG, a16};
        else nextBad = 1'b1;
      end
      SPACE_CFG:    nextData = 32'(cfgQ);
      default:      nextData = protWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      presQ  <= '0;
      spaceQ <= SPACE_MAIN;
      dataQ  <= '0;
      validQ <= 1'b0;
      lastQ  <= 1'b0;
      badQ   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        baseQ  <= addr;
        spaceQ <= space_e'(space);
      end
      if (ctl.capture || ctl.clear) begin
        validQ <= 1'b0;
        lastQ  <= 1'b0;
        badQ   <= 1'b0;
      end else if (ctl.load) begin
        dataQ  <= nextData;
        presQ  <= beatAddr;
        validQ <= 1'b1;
        lastQ  <= ctl.last;
        badQ   <= nextBad;
      end
    end
  end

  logic showQ;
  assign showQ   = validQ && outEn;
  assign rdValid = showQ;
  assign rdLast  = showQ && lastQ;
  assign rdBad   = showQ && badQ;
  assign rdData  = showQ ? dataQ : '0;

  assert_strobe_invalidates_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> !validQ);

  assert_wrap_to_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && lastQ && ctl.load) |=> (presQ == baseQ));

  assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !lastQ && ctl.load) |=>
      (((presQ - $past(presQ)) & ADDR_W'($past(ctl.mask))) == ADDR_W'(1)));

  assert_bad_is_secure_R10: assert property (@(posedge clk) disable iff (!rstN)
    badQ |-> (spaceQ == SPACE_SECURE && dataQ == '0));

  assert_last_not_register_R8: assert property (@(posedge clk) disable iff (!rstN)
    lastQ |-> (spaceQ == SPACE_MAIN || spaceQ == SPACE_SECURE));

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bsr_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               SEC_WORDS = 64,
  parameter int               PROT_W    = 8,
  parameter logic [PROT_W-1:0] PROT_INIT = 8'h5A,
  parameter logic [6:0]        CFG_RESET = 7'b0000_010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        space,
  input  logic              outEn,
  input  logic              cfgWrEn,
  input  logic [6:0]        cfgWrData,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              rdLast,
  output logic              rdBad
);

  cfg_t    cfgQ;
  dp_ctl_t ctl;

  bsr_ctrl #(.CFG_RESET(CFG_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .space(space),
    .outEn(outEn), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgQ(cfgQ), .ctl(ctl)
  );

  bsr_datapath #(
    .ADDR_W(ADDR_W), .SEC_WORDS(SEC_WORDS), .PROT_W(PROT_W), .PROT_INIT(PROT_INIT)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .addr(addr), .space(space), .outEn(outEn),
    .ctl(ctl), .cfgQ(cfgQ),
    .rdData(rdData), .rdValid(rdValid), .rdLast(rdLast), .rdBad(rdBad)
  );

endmodule

// File: tb/burst_read_seq_bench.sv
`timescale 1ns/1ps
module burst_read_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  space = '0;
  logic        outEn = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgWrData = '0;
  logic [31:0] rdData;
  logic        rdValid, rdLast, rdBad;

  always #2.5 clk = ~clk;

  burst_read_seq u_burst_read_seq (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addr(addr), .space(space),
    .outEn(outEn), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .rdData(rdData), .rdValid(rdValid), .rdLast(rdLast), .rdBad(rdBad)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    running = 1'b0;

  // ---------------- reference model ----------------
  logic [6:0]  mCfg = 7'b0000_010;
  int          edgeNo = 0, sEdge = 0, sLat = 2, sN = 2;
  logic [15:0] sBase = '0;
  logic [1:0]  sSpace = '0;
  bit          sBurst = 1'b0, active = 1'b0;
  logic [31:0] eData = '0;
  bit          eValid = 1'b0, eLast = 1'b0, eBad = 1'b0;

  function automatic int latOf(logic [6:0] c);
    return (c[6:3] == 4'hF) ? 16 : int'(c[6:3]) + 2;
  endfunction

  function automatic int lenOf(logic [6:0] c);
    return (c[2:1] == 2'd0) ? 2 : (c[2:1] == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [31:0] wordAt(logic [1:0] sp, logic [15:0] a, logic [6:0] c,
                                         output bit bad);
    bad = 1'b0;
    case (sp)
      2'd0: return {a ^ 16'hC3A5, a};                      // R12
      2'd1: begin                                          // R10
        if (a < 16'd64) return {16'h5EC0, a};
        bad = 1'b1;
        return 32'h0;
      end
      2'd2: return {25'b0, c};                             // R8
      default: return 32'h0000_005A;
    endcase
  endfunction

  always @(posedge clk) begin
    int k, b;
    logic [15:0] a, m;
    edgeNo++;
    if (!rstN) begin
      mCfg = 7'b0000_010; active = 0; eValid = 0; eLast = 0; eBad = 0; eData = 0;
    end else begin
      if (addrValid) begin
        sBase = addr; sSpace = space; sEdge = edgeNo;
        sLat = latOf(mCfg); sN = lenOf(mCfg);
        sBurst = mCfg[0] && (space < 2'd2);
        active = 1; eValid = 0; eLast = 0; eBad = 0;
      end else if (active) begin
        k = edgeNo - sEdge - sLat;
        if (k >= 0) begin
          if (sBurst) begin
            b = k % sN;
            m = 16'(sN - 1);
            a = (sBase & ~m) | ((sBase + 16'(b)) & m);
            eData = wordAt(sSpace, a, mCfg, eBad);
            eValid = 1; eLast = (b == sN - 1);
          end else if (k == 0) begin
            eData = wordAt(sSpace, sBase, mCfg, eBad);
            eValid = 1; eLast = 0;
          end else if (!outEn) begin
            eValid = 0; eLast = 0; eBad = 0; active = 0;
          end
        end
      end
      if (cfgWrEn) mCfg = cfgWrData;
    end
  end

  // ---------------- comparison, every clock ----------------
  task automatic compareNow();
    logic [34:0] act, exp;
    bit sh;
    sh  = eValid && outEn;
    act = {rdValid, rdLast, rdBad, rdData};
    exp = {sh, sh && eLast, sh && eBad, sh ? eData : 32'h0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t valid/last/bad/data actual=%b/%b/%b/%h expected=%b/%b/%b/%h",
               curReq, $time, act[34], act[33], act[32], act[31:0],
               exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  always @(negedge clk) if (running) compareNow();

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(logic [1:0] sp, logic [15:0] a);
    addr = a; space = sp; addrValid = 1'b1;
    tick(1);
    addrValid = 1'b0;
  endtask

  task automatic writeCfg(logic [3:0] lat, logic [1:0] len, logic on);
    cfgWrData = {lat, len, on}; cfgWrEn = 1'b1;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    outEn = 1'b1;
    tick(1);
    // R1: reset state at the ports
    checks++;
    if ({rdValid, rdLast, rdBad, rdData} !== 35'h0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%h expected=0", {rdValid, rdLast, rdBad, rdData});
    end
    running = 1'b1;

    // R7 R3 R12: default config, single read held by outEn, then released (R11)
    curReq = "R7 R3 R12 R1";
    strobe(2'd0, 16'h1234); tick(8);
    curReq = "R7 R11";
    outEn = 1'b0; tick(3); outEn = 1'b1; tick(3);

    // R4 R5 R6: 2-word burst, latency 2
    curReq = "R2 R4 R5 R6";
    writeCfg(4'd0, 2'd0, 1'b1); strobe(2'd0, 16'h0005); tick(10);
    // 4-word burst, latency 5, start mid-group
    curReq = "R3 R4 R5 R6";
    writeCfg(4'd3, 2'd1, 1'b1); strobe(2'd0, 16'h1236); tick(16);
    // 8-word burst, code 15 -> latency 16
    writeCfg(4'd15, 2'd2, 1'b1); strobe(2'd0, 16'h0FFD); tick(34);
    // length select 11 -> 8 words, code 14 -> latency 16
    curReq = "R2";
    writeCfg(4'd14, 2'd3, 1'b1); strobe(2'd0, 16'h2003); tick(26);

    // R9: strobe mid-burst and during latency
    curReq = "R9";
    writeCfg(4'd1, 2'd1, 1'b1); strobe(2'd0, 16'h0040); tick(6);
    strobe(2'd0, 16'h0081); tick(1);
    strobe(2'd0, 16'h0090); tick(9);

    // R2: configuration write on the same edge as a strobe keeps the old setting
    curReq = "R2";
    cfgWrData = {4'd0, 2'd0, 1'b1}; cfgWrEn = 1'b1;
    addr = 16'h0300; space = 2'd0; addrValid = 1'b1;
    tick(1);
    cfgWrEn = 1'b0; addrValid = 1'b0;
    tick(12);
    strobe(2'd0, 16'h0310); tick(8);

    // R8: register and protection reads stay single in burst mode
    curReq = "R8";
    writeCfg(4'd2, 2'd2, 1'b1); strobe(2'd2, 16'h0000); tick(10);
    strobe(2'd3, 16'h0007); tick(10);

    // R10: secure region inside and beyond the limit
    curReq = "R10";
    strobe(2'd1, 16'd60); tick(16);
    strobe(2'd1, 16'd70); tick(12);

    // R11: output enable dropped during a burst
    curReq = "R11";
    strobe(2'd0, 16'h5555); tick(6);
    outEn = 1'b0; tick(5); outEn = 1'b1; tick(6);

    // R7: bursts disabled, longer latency, main and secure
    curReq = "R7";
    writeCfg(4'd5, 2'd2, 1'b0); strobe(2'd0, 16'h0777); tick(12);
    strobe(2'd1, 16'h0010); tick(10);

    running = 1'b0;
    summary();
    $finish;
  end

endmodule